// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-level model of a single-port synchronous static memory with flow-through reads. Every input except the output enable is sampled on the rising clock edge. The word read at the address used on an edge appears on the read-data port during the cycle that follows that edge, with no further register stage. The word is 18 bits wide and is split into two 9-bit lanes. Each lane holds eight data bits and one parity bit, and each lane can be written on its own.

An access begins when one of two address strobes loads an external address. The processor strobe always starts a read. The controller strobe starts a read or a write, and it can also put the device into its deselected power-down state. Once an address is loaded, an advance input steps a 2-bit burst offset in either linear or interleaved order. When no strobe and no advance are given, the device stays on the current address for a wait state. Three chip enables are looked at only when an address is loaded.

The data bus is modelled as separate write-data, read-data and read-drive ports. The read-drive port also depends on an asynchronous output-enable input. The array depth is set by a parameter, so the model can be simulated at a small size.

Top module: `sync_burst_sram`

## Requirements
- R1: When `gw_n` is low on a write-capable cycle (controller-strobe load, advance or suspend), all 18 bits at the addressed word are written from `wdata`, whatever `bwe_n` and `bw_n` are.
- R2: When `gw_n` is high and `bwe_n` is low, each lane whose `bw_n` bit is low is written. Lane a is `bw_n[0]` and covers bits 8:0 (data 7:0, parity 8). Lane b is `bw_n[1]` and covers bits 17:9 (data 16:9, parity 17).
- R3: When `gw_n` is high and either `bwe_n` is high or both `bw_n` bits are high, the cycle is a read. The word is not changed and it is driven on the read bus.
- R4: A low `pstb_n` with `ce_n` low loads `addr` and performs a read, whatever the write inputs and `cstb_n` are. A low `pstb_n` while `ce_n` is high is ignored, and the burst continues or waits as the advance input directs.
- R5: A low `cstb_n` with `ce_n` low loads `addr` and performs a read or a write. A low `cstb_n` with `ce_n` high deselects the device, and the device then stays deselected until an accepted load selects it again.
- R6: A load selects the device only if `ce_n` is low, `ce2_n` is low and `ce2` is high. The chip enables are ignored on cycles that do not load an address.
- R7: When `adv_n` is low and no strobe is accepted, the 2-bit burst offset steps by one and wraps after four words. The offset is XORed with the low two loaded address bits when `seq_interleave` is 1, and added to them modulo 4 when it is 0. The upper address bits never change within a burst.
- R8: When `adv_n` is high and no strobe is accepted, the address stays where it is (a wait state). A write that follows a processor-strobe read lands on that held address, using the write inputs sampled on that edge.
- R9: After each read edge, `rdata` shows the word at the address used on that edge, in the cycle that follows the edge (flow-through).
- R10: `rdata_oe` is low while the device is deselected and after a write cycle, until a read cycle is performed. It is also low whenever `oe_n` is high, and this takes effect without waiting for a clock edge.
- R11: When `pstb_n`, `cstb_n` and `ce_n` are all low, the processor strobe wins: the cycle is a read, and nothing is written.
- R12: Synchronous active-high `rst` leaves the device deselected with `rdata_oe` low. The array contents after reset are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Secondary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Lane write enables, active low, bit 0 = lane a |
| seq_interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 18 | Write data, lane b in 17:9, lane a in 8:0 |
| rdata | output | 18 | Flow-through read data |
| rdata_oe | output | 1 | Read bus drive enable |

## Verification
A corrupted selection flag would show up as `rdata_oe` asserted after a deselecting controller strobe, or held low after a valid load, in the cycle right after the edge. A burst register that is wrong, or a processor strobe that writes when it should not, shows up as the wrong word on `rdata` in the cycle after the offending edge. A write that was dropped or misplaced is seen on the next read of that address. The directed scenarios cover each of these cases: lane masking, both burst orders including wrap, a wait state, strobe priority, and power-down.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    parameter int LANE_W    = 9;
    parameter int LANES     = 2;
    parameter int WORD_W    = LANE_W * LANES;
    parameter int BURST_LEN = 4;
    parameter int OFS_W     = $clog2(BURST_LEN);

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [2:0] {
        CMD_IDLE,      // deselected, nothing accepted
        CMD_POWERDOWN, // controller strobe with primary enable off
        CMD_LOAD_PROC, // processor strobe load, read only
        CMD_LOAD_CTRL, // controller strobe load, read or write
        CMD_STEP,      // advance burst offset
        CMD_HOLD       // wait state on current address
    } cmd_e;

    // Sampled controls, converted to active-high meaning.
    typedef struct packed {
        logic       proc_stb;
        logic       ctrl_stb;
        logic       advance;
        logic       en_primary;
        logic       en_secondary;
        logic       global_wr;
        logic       byte_wr;
        lane_mask_t lane_en;
    } ctl_t;

    function automatic lane_mask_t write_mask(input ctl_t c);
        if (c.global_wr)
            return '1;
        else if (c.byte_wr)
            return c.lane_en;
        else
            return '0;
    endfunction

    function automatic ofs_t burst_ofs(input ofs_t base, input ofs_t cnt,
                                       input logic interleave);
        return interleave ? (base ^ cnt) : ofs_t'(base + cnt);
    endfunction

    function automatic cmd_e decode_cmd(input ctl_t c, input logic selected);
        if (c.proc_stb && c.en_primary)
            return CMD_LOAD_PROC;
        else if (c.ctrl_stb)
            return c.en_primary ? CMD_LOAD_CTRL : CMD_POWERDOWN;
        else if (!selected)
            return CMD_IDLE;
        else if (c.advance)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
(
    input  ctl_t       ctl,
    input  logic       sel_q,
    output logic       load,
    output logic       step,
    output logic       sel_next,
    output logic       rd_next,
    output lane_mask_t wr_lanes
);

    cmd_e       cmd;
    lane_mask_t mask;
    logic       en_all;

    always_comb begin
        cmd      = decode_cmd(ctl, sel_q);
        mask     = write_mask(ctl);
        en_all   = ctl.en_primary && ctl.en_secondary;
        load     = (cmd == CMD_LOAD_PROC) || (cmd == CMD_LOAD_CTRL);
        step     = (cmd == CMD_STEP);
        sel_next = 1'b0;
        rd_next  = 1'b0;
        wr_lanes = '0;
        unique case (cmd)
            CMD_LOAD_PROC: begin
                sel_next = en_all;
                rd_next  = en_all;
            end
            CMD_LOAD_CTRL: begin
                sel_next = en_all;
                wr_lanes = en_all ? mask : '0;
                rd_next  = en_all && (mask == '0);
            end
            CMD_STEP, CMD_HOLD: begin
                sel_next = 1'b1;
                wr_lanes = mask;
                rd_next  = (mask == '0);
            end
            default: begin
                sel_next = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);

    localparam int HI_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] base_q, base_n;
    ofs_t              cnt_q, cnt_n;

    always_comb begin
        base_n = load ? load_addr : base_q;
        if (load)
            cnt_n = '0;
        else if (step)
            cnt_n = ofs_t'(cnt_q + ofs_t'(1));
        else
            cnt_n = cnt_q;
        nxt_addr = {base_n[ADDR_W-1:OFS_W],
                    burst_ofs(base_n[OFS_W-1:0], cnt_n, interleave)};
        cur_addr = {base_q[ADDR_W-1:OFS_W],
                    burst_ofs(base_q[OFS_W-1:0], cnt_q, interleave)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
        end
    end

    // R8: a wait state keeps the address (unless the order pin moves)
    a_r8_hold_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(cur_addr) || !$stable(interleave)));

    // R7: stepping never leaves the aligned block of BURST_LEN words
    a_r7_block_fixed: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> (cur_addr[ADDR_W-1:OFS_W] ==
                             $past(cur_addr[ADDR_W-1:OFS_W])));

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  lane_mask_t        wr_lanes,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce2_n,
    input  logic              ce2,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [1:0]        bw_n,
    input  logic              seq_interleave,
    input  logic              oe_n,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              rdata_oe
);

    ctl_t              ctl;
    logic              sel_q, rd_q;
    logic              load, step, sel_next, rd_next;
    lane_mask_t        wr_lanes;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;

    always_comb begin
        ctl.proc_stb     = !pstb_n;
        ctl.ctrl_stb     = !cstb_n;
        ctl.advance      = !adv_n;
        ctl.en_primary   = !ce_n;
        ctl.en_secondary = !ce2_n && ce2;
        ctl.global_wr    = !gw_n;
        ctl.byte_wr      = !bwe_n;
        ctl.lane_en      = ~bw_n;
    end

    sbsram_decode u_decode (
        .ctl      (ctl),
        .sel_q    (sel_q),
        .load     (load),
        .step     (step),
        .sel_next (sel_next),
        .rd_next  (rd_next),
        .wr_lanes (wr_lanes)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .interleave (seq_interleave),
        .load_addr  (addr),
        .cur_addr   (cur_addr),
        .nxt_addr   (nxt_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .wr_lanes (wr_lanes),
        .waddr    (nxt_addr),
        .wdata    (wdata),
        .raddr    (cur_addr),
        .rdata    (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            sel_q <= sel_next;
            rd_q  <= rd_next;
        end
    end

    assign rdata_oe = rd_q && !oe_n;

    // R12: reset leaves the part deselected and quiet
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sel_q && !rd_q));

    // R4: an accepted processor strobe with full enables reads
    a_r4_proc_reads: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n && !ce_n && !ce2_n && ce2) |=> rd_q);

    // R5: controller strobe with primary enable off powers down
    a_r5_ctrl_powerdown: assert property (@(posedge clk) disable iff (rst)
        (!cstb_n && ce_n) |=> !sel_q);

    // R6: a load with a secondary enable off leaves the part deselected
    a_r6_partial_enable: assert property (@(posedge clk) disable iff (rst)
        (((!pstb_n && !ce_n) || !cstb_n) && (ce2_n || !ce2)) |=> !sel_q);

    // R10: a global write on a continuing cycle leaves the bus undriven
    a_r10_write_hides_bus: assert property (@(posedge clk) disable iff (rst)
        (sel_q && cstb_n && (pstb_n || ce_n) && !gw_n) |=> !rdata_oe);

    // R10: no drive while deselected
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel_q |-> !rdata_oe);

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

    localparam int  PERIOD = 10;
    localparam int  AW     = 8;
    localparam int  DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          pstb_n, cstb_n, adv_n, ce_n, ce2_n, ce2;
    logic          gw_n, bwe_n;
    logic [1:0]    bw_n;
    logic          seq_interleave, oe_n;
    logic [17:0]   wdata, rdata;
    logic          rdata_oe;

    int n_chk = 0;
    int n_err = 0;
    logic [17:0] shadow [DEPTH];

    always #(PERIOD/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .adv_n(adv_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .seq_interleave(seq_interleave),
        .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'(a * 1237 + 18'h2A3C5);
    endfunction

    task automatic chk(input string req, input logic [17:0] act,
                       input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    task automatic idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1;
        ce_n = 0; ce2_n = 0; ce2 = 1;
        gw_n = 1; bwe_n = 1; bw_n = 2'b11; wdata = '0;
    endtask

    task automatic ctrl_write(input int a, input logic [17:0] d);
        idle(); cstb_n = 0; addr = AW'(a); gw_n = 0; wdata = d;
        tick();
        shadow[a] = d;
        idle();
    endtask

    task automatic ctrl_read(input string req, input int a);
        idle(); cstb_n = 0; addr = AW'(a);
        tick();
        chk(req, rdata, shadow[a]);
        chk(req, {17'b0, rdata_oe}, 18'd1);
        idle();
    endtask

    task automatic t_reset();
        chk("R12 oe after reset", {17'b0, rdata_oe}, 18'd0);
        tick();
        chk("R12 still deselected", {17'b0, rdata_oe}, 18'd0);
    endtask

    task automatic t_full_write();
        ctrl_write(16, 18'h2A5A5);
        chk("R10 undriven after write", {17'b0, rdata_oe}, 18'd0);
        ctrl_read("R1 R5 R9 full write read", 16);
    endtask

    task automatic t_lanes();
        logic [17:0] ma;
        ctrl_write(32, 18'h3FFFF);
        ma = 18'h001FF;
        idle(); cstb_n = 0; addr = 8'd32; bwe_n = 0; bw_n = 2'b10; wdata = 0;
        tick();
        shadow[32] = (shadow[32] & ~ma) | (18'h0 & ma);
        idle();
        idle(); cstb_n = 0; addr = 8'd32; bwe_n = 0; bw_n = 2'b01;
        wdata = 18'h15555;
        tick();
        shadow[32] = (shadow[32] & ma) | (18'h15555 & ~ma);
        idle();
        ctrl_read("R2 lane a then lane b", 32);
        chk("R2 expected word", shadow[32], 18'h15400);
        idle(); cstb_n = 0; addr = 8'd32; bwe_n = 0; bw_n = 2'b11; wdata = 0;
        tick();
        chk("R3 bwe low no lanes reads", rdata, 18'h15400);
        chk("R3 bwe low no lanes drives", {17'b0, rdata_oe}, 18'd1);
        idle(); cstb_n = 0; addr = 8'd32; bwe_n = 1; bw_n = 2'b00; wdata = 0;
        tick();
        chk("R3 bwe high reads", rdata, 18'h15400);
        idle();
    endtask

    task automatic t_burst();
        int lin [5] = '{49, 50, 51, 48, 49};
        int ilv [4] = '{49, 48, 51, 50};
        for (int a = 48; a < 52; a++) ctrl_write(a, pat(a));
        seq_interleave = 0;
        ctrl_read("R7 linear first", 49);
        for (int i = 1; i < 5; i++) begin
            idle(); adv_n = 0;
            tick();
            chk($sformatf("R7 linear step %0d", i), rdata, shadow[lin[i]]);
        end
        idle();
        seq_interleave = 1;
        ctrl_read("R7 interleaved first", 49);
        for (int i = 1; i < 4; i++) begin
            idle(); adv_n = 0;
            tick();
            chk($sformatf("R7 interleaved step %0d", i), rdata, shadow[ilv[i]]);
        end
        idle();
        tick();
        chk("R8 wait state holds", rdata, shadow[50]);
        idle(); adv_n = 0; ce_n = 1; ce2 = 0;
        tick();
        chk("R6 enables ignored on step", rdata, shadow[49]);
        chk("R6 still driven", {17'b0, rdata_oe}, 18'd1);
        idle();
        seq_interleave = 0;
    endtask

    task automatic t_proc_write();
        idle(); pstb_n = 0; addr = 8'd51;
        tick();
        chk("R4 proc read", rdata, shadow[51]);
        chk("R9 proc read drives", {17'b0, rdata_oe}, 18'd1);
        idle(); gw_n = 0; wdata = 18'h0BEEF;
        tick();
        shadow[51] = 18'h0BEEF;
        chk("R8 follow-on write hides bus", {17'b0, rdata_oe}, 18'd0);
        idle();
        ctrl_read("R8 follow-on write landed", 51);
    endtask

    task automatic t_proc_ignores();
        idle(); pstb_n = 0; addr = 8'd48; gw_n = 0; wdata = 18'h11111;
        tick();
        chk("R4 write inputs ignored", rdata, shadow[48]);
        idle();
        tick();
        chk("R4 word unchanged", rdata, shadow[48]);
        idle(); pstb_n = 0; ce_n = 1; addr = 8'd32;
        tick();
        chk("R4 strobe ignored with ce_n high", rdata, shadow[48]);
        chk("R4 still driven", {17'b0, rdata_oe}, 18'd1);
        idle();
    endtask

    task automatic t_priority();
        idle(); pstb_n = 0; cstb_n = 0; addr = 8'd49; gw_n = 0;
        wdata = 18'h22222;
        tick();
        chk("R11 proc wins read", rdata, shadow[49]);
        chk("R11 drives", {17'b0, rdata_oe}, 18'd1);
        idle();
        tick();
        chk("R11 nothing written", rdata, shadow[49]);
    endtask

    task automatic t_deselect();
        idle(); cstb_n = 0; ce_n = 1;
        tick();
        chk("R5 powerdown", {17'b0, rdata_oe}, 18'd0);
        idle(); adv_n = 0;
        tick();
        chk("R5 stays deselected", {17'b0, rdata_oe}, 18'd0);
        idle(); pstb_n = 0; addr = 8'd16; ce2 = 0;
        tick();
        chk("R6 ce2 low deselects", {17'b0, rdata_oe}, 18'd0);
        idle(); cstb_n = 0; addr = 8'd16; ce2_n = 1;
        tick();
        chk("R6 ce2_n high deselects", {17'b0, rdata_oe}, 18'd0);
        idle();
    endtask

    task automatic t_oe();
        ctrl_read("R10 read before oe test", 16);
        oe_n = 1; #1;
        chk("R10 oe_n high blocks", {17'b0, rdata_oe}, 18'd0);
        oe_n = 0; #1;
        chk("R10 oe_n low restores", {17'b0, rdata_oe}, 18'd1);
    endtask

    initial begin
        #(PERIOD * 5000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(); addr = '0; seq_interleave = 0; oe_n = 0; rst = 1;
        for (int a = 0; a < DEPTH; a++) shadow[a] = '0;
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_full_write();
        t_lanes();
        t_burst();
        t_proc_write();
        t_proc_ignores();
        t_priority();
        t_deselect();
        t_oe();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule